// File: doc/BRIEF.md
# Receive Packet Port with Status Dword

This block is the user-facing receive side of a serial storage link. It takes 32-bit Dwords from a show-ahead receive FIFO and presents them to user logic with active-low start, end and valid markers. A received Dword is counted as transferred on every cycle in which valid is low. The user throttles the stream with an active-low ready. Because that ready passes through a fixed pipeline, the user must drop ready while it still has room for the words already in flight.

Every finished packet is followed by a one-word status packet. The status word carries a fixed type byte, the transfer direction and a two-bit error class. The transmit path reports completed writes through a pulse and an error class. The block then emits a status word for that direction once no receive packet is open.

Packets can be cancelled from either side. The user can pulse an abort, which makes the block request a SYNC abort from the link. The link can report that the far end sent SYNC, which makes the block pulse a source-abort marker to the user. In both cases the rest of the packet is flushed from the FIFO.

Top module: `rxp_rx_port`

## Requirements
- R1: While reset is asserted and right after it is released, rx_vld_n, rx_sof_n, rx_eof_n and rx_src_abort_n are 1, and lnk_sync_req and fifo_pop are 0.
- R2: rx_sof_n is low on the first data Dword of a packet and rx_eof_n is low on its last Dword, which is the FIFO entry whose fifo_last is 1. Both markers are low on a one-word packet. Neither marker is ever low while rx_vld_n is high.
- R3: A status word has bits [7:0] = 8'hEF, bit 26 = direction (1 = received by this port, 0 = transmit path), bits [25:24] = error class (00 none, 01 bad packet, 10 CRC, 11 reserved), and every other bit zero.
- R4: After the last Dword of a received packet, the next valid Dword is a status word with direction 1 and the fifo_err of that last entry. It is presented with rx_sof_n and rx_eof_n both low.
- R5: rx_vld_n is high no later than STOP_LAT cycles after usr_rdy_n goes high. With a continuously filled FIFO, exactly STOP_LAT Dwords are presented while usr_rdy_n is high. No Dword is presented while usr_rdy_n has been high for longer than that.
- R6: Every entry popped from the FIFO is presented in the next cycle, in FIFO order, with none dropped.
- R7: A tx_done pulse with error class tx_err causes one status word with direction 0. While a receive packet is open, this status word is held back until that packet's end and its receive status word have been presented.
- R8: A low pulse on usr_abort_n while a packet is open stops the output from the next cycle on. The block raises lnk_sync_req for exactly one cycle and pulses fifo_flush. No further Dword of that packet is presented, and no status word is sent for it. A packet is open after its start Dword has been presented and before its end Dword has been presented.
- R9: A high pulse on lnk_sync_rcvd while a packet is open drives rx_src_abort_n low for exactly one cycle, with rx_vld_n high in that cycle. It also pulses fifo_flush and presents no further Dword of that packet.
- R10: Abort pulses on usr_abort_n or lnk_sync_rcvd while no packet is open have no effect, and the following packet is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| usr_rdy_n | input | 1 | User ready, active low |
| usr_abort_n | input | 1 | User read abort pulse, active low |
| rx_data | output | 32 | Delivered Dword (data or status) |
| rx_sof_n | output | 1 | Start-of-packet marker, active low |
| rx_eof_n | output | 1 | End-of-packet marker, active low |
| rx_vld_n | output | 1 | Dword valid, active low |
| rx_src_abort_n | output | 1 | Link-side cancel pulse toward user, active low |
| fifo_valid | input | 1 | FIFO holds at least one entry |
| fifo_data | input | 32 | Head entry data |
| fifo_last | input | 1 | Head entry ends its packet |
| fifo_err | input | 2 | Error class attached to the head entry, used on the last entry |
| fifo_pop | output | 1 | Remove the head entry |
| fifo_flush | output | 1 | Discard all FIFO entries |
| lnk_sync_rcvd | input | 1 | Far end cancelled the packet with SYNC |
| lnk_sync_req | output | 1 | Request to send a SYNC abort on the link |
| tx_done | input | 1 | Transmit packet finished |
| tx_err | input | 2 | Error class of the finished transmit packet |

## Verification
The bench builds the port with STOP_LAT = 4. At that value a continuously filled FIFO makes the overrun after ready rises exactly four Dwords, so both the upper bound and the exact count can be observed at the ports. The FIFO model is filled far ahead of the user, which keeps the output stream saturated. That brings the no-drop ordering across a ready stall, aborts in mid-stream with entries still queued, and transmit status held behind an open receive packet all within reach.

// File: rtl/rxp_pkg.sv
`timescale 1ns/1ps
package rxp_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam logic [7:0]  STAT_TAG = 8'hEF;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // Status Dword: tag in [7:0], error class in [25:24], direction in [26]
  function automatic logic [WORD_W-1:0] stat_word(dir_e d, logic [1:0] e);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = STAT_TAG;
    w[25:24] = e;
    w[26]    = d;
    return w;
  endfunction
endpackage

// File: rtl/rxp_stop_pipe.sv
`timescale 1ns/1ps
// Delays the user ready so that the output register reacts STOP_LAT edges
// after ready is first sampled high.
module rxp_stop_pipe #(
  parameter int unsigned STOP_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic usr_rdy_n,
  output logic go
);
  localparam int unsigned STG = (STOP_LAT > 1) ? STOP_LAT - 1 : 1;

  generate
    if (STOP_LAT < 2) begin : g_direct
      assign go = !usr_rdy_n;
    end else begin : g_piped
      logic [STG-1:0] sh_q, sh_d;

      always_comb begin
        sh_d[0] = usr_rdy_n;
        for (int i = 1; i < int'(STG); i++) sh_d[i] = sh_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
      end

      assign go = !sh_q[STG-1];
    end
  endgenerate
endmodule

// File: rtl/rxp_stat_pend.sv
`timescale 1ns/1ps
// Pending status flags for both directions, with their error classes.
module rxp_stat_pend (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_set,
  input  logic [1:0] rx_err,
  input  logic       rx_take,
  input  logic       tx_set,
  input  logic [1:0] tx_err,
  input  logic       tx_take,
  output logic       rx_pend,
  output logic [1:0] rx_err_q,
  output logic       tx_pend,
  output logic [1:0] tx_err_q
);
  logic rx_pend_d, tx_pend_d;

  always_comb begin
    rx_pend_d = rx_set ? 1'b1 : (rx_take ? 1'b0 : rx_pend);
    tx_pend_d = tx_set ? 1'b1 : (tx_take ? 1'b0 : tx_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      rx_pend <= rx_pend_d;
      tx_pend <= tx_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_err_q <= '0;
    else if (rx_set) rx_err_q <= rx_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_err_q <= '0;
    else if (tx_set) tx_err_q <= tx_err;
  end
endmodule

// File: rtl/rxp_rx_port.sv
`timescale 1ns/1ps
module rxp_rx_port
  import rxp_pkg::*;
#(
  parameter int unsigned STOP_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_rdy_n,
  input  logic              usr_abort_n,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_sof_n,
  output logic              rx_eof_n,
  output logic              rx_vld_n,
  output logic              rx_src_abort_n,
  input  logic              fifo_valid,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_last,
  input  logic [1:0]        fifo_err,
  output logic              fifo_pop,
  output logic              fifo_flush,
  input  logic              lnk_sync_rcvd,
  output logic              lnk_sync_req,
  input  logic              tx_done,
  input  logic [1:0]        tx_err
);
  logic       go;
  logic       in_pkt_q, in_pkt_d;
  logic       rx_pend, tx_pend;
  logic [1:0] rx_err_q, tx_err_q;
  logic       usr_abort, lnk_abort, any_abort;
  logic       send_rx, send_tx, send_dat, tx_ok, load;
  logic       vld_n_d, sof_n_d, eof_n_d;
  logic [WORD_W-1:0] data_d;

  rxp_stop_pipe #(.STOP_LAT(STOP_LAT)) u_stop (
    .clk(clk), .rst_n(rst_n), .usr_rdy_n(usr_rdy_n), .go(go)
  );

  rxp_stat_pend u_stat (
    .clk(clk), .rst_n(rst_n),
    .rx_set(send_dat && fifo_last), .rx_err(fifo_err), .rx_take(send_rx),
    .tx_set(tx_done), .tx_err(tx_err), .tx_take(send_tx),
    .rx_pend(rx_pend), .rx_err_q(rx_err_q),
    .tx_pend(tx_pend), .tx_err_q(tx_err_q)
  );

  // Aborts only count while a packet is open
  always_comb begin
    usr_abort = !usr_abort_n && in_pkt_q;
    lnk_abort = lnk_sync_rcvd && in_pkt_q;
    any_abort = usr_abort || lnk_abort;
    tx_ok     = tx_pend && !in_pkt_q;
    send_rx   = !any_abort && go && rx_pend;
    send_tx   = !any_abort && go && !rx_pend && tx_ok;
    send_dat  = !any_abort && go && !rx_pend && !tx_ok && fifo_valid;
    load      = send_rx || send_tx || send_dat;
    fifo_pop   = send_dat;
    fifo_flush = any_abort;
  end

  always_comb begin
    in_pkt_d = in_pkt_q;
    if (any_abort)     in_pkt_d = 1'b0;
    else if (send_dat) in_pkt_d = !fifo_last;

    vld_n_d = !load;
    sof_n_d = 1'b1;
    eof_n_d = 1'b1;
    data_d  = fifo_data;
    if (send_rx) begin
      sof_n_d = 1'b0;
      eof_n_d = 1'b0;
      data_d  = stat_word(DIR_RX, rx_err_q);
    end else if (send_tx) begin
      sof_n_d = 1'b0;
      eof_n_d = 1'b0;
      data_d  = stat_word(DIR_TX, tx_err_q);
    end else if (send_dat) begin
      sof_n_d = in_pkt_q;
      eof_n_d = !fifo_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q       <= 1'b0;
      rx_vld_n       <= 1'b1;
      rx_sof_n       <= 1'b1;
      rx_eof_n       <= 1'b1;
      rx_src_abort_n <= 1'b1;
      lnk_sync_req   <= 1'b0;
    end else begin
      in_pkt_q       <= in_pkt_d;
      rx_vld_n       <= vld_n_d;
      rx_sof_n       <= sof_n_d;
      rx_eof_n       <= eof_n_d;
      rx_src_abort_n <= !lnk_abort;
      lnk_sync_req   <= usr_abort;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_data <= '0;
    else if (load) rx_data <= data_d;
  end

  // ---------------- assertions ----------------
  localparam int unsigned CW = $clog2(STOP_LAT + 1) + 1;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_cnt <= '0;
    else if (!usr_rdy_n)              hi_cnt <= '0;
    else if (hi_cnt != CW'(STOP_LAT)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_sof_n || !rx_eof_n) |-> !rx_vld_n);

  a_r5_stop_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= CW'(STOP_LAT)) |-> rx_vld_n);

  a_r6_pop_presented: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !rx_vld_n);

  a_r8_sync_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_sync_req |=> !lnk_sync_req);

  a_r8_sync_stops: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_sync_req |-> rx_vld_n);

  a_r9_src_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_src_abort_n |=> rx_src_abort_n);

  a_r9_src_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_src_abort_n |-> rx_vld_n);
endmodule

// File: tb/rxp_rx_port_bench.sv
`timescale 1ns/1ps
module rxp_rx_port_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, usr_rdy_n, usr_abort_n, lnk_sync_rcvd, tx_done;
  logic [1:0]  tx_err;
  logic [31:0] rx_data;
  logic        rx_sof_n, rx_eof_n, rx_vld_n, rx_src_abort_n;
  logic        fifo_valid, fifo_last, fifo_pop, fifo_flush, lnk_sync_req;
  logic [31:0] fifo_data;
  logic [1:0]  fifo_err;

  rxp_rx_port #(.STOP_LAT(4)) u_rxp_rx_port (
    .clk(clk), .rst_n(rst_n), .usr_rdy_n(usr_rdy_n), .usr_abort_n(usr_abort_n),
    .rx_data(rx_data), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n), .rx_vld_n(rx_vld_n),
    .rx_src_abort_n(rx_src_abort_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_err(fifo_err), .fifo_pop(fifo_pop),
    .fifo_flush(fifo_flush), .lnk_sync_rcvd(lnk_sync_rcvd), .lnk_sync_req(lnk_sync_req),
    .tx_done(tx_done), .tx_err(tx_err)
  );

  // FIFO model: entry = {err, last, data}
  logic [34:0] mem [0:63];
  int wp = 0, rp = 0;
  logic pop_s = 1'b0, flush_s = 1'b0;
  assign fifo_valid = (wp != rp);
  assign {fifo_err, fifo_last, fifo_data} = mem[rp[5:0]];

  always @(negedge clk) begin
    #1;
    pop_s   = fifo_pop;
    flush_s = fifo_flush;
  end
  always @(posedge clk) begin
    if (flush_s)    rp <= wp;
    else if (pop_s) rp <= rp + 1;
  end

  // Output monitor
  logic [31:0] lg_d [0:255];
  logic        lg_s [0:255];
  logic        lg_e [0:255];
  int lg_n = 0, streak = 0, max_streak = 0, sync_cnt = 0, abrt_cnt = 0;
  always @(negedge clk) begin
    #2;
    if (!rx_vld_n && lg_n < 256) begin
      lg_d[lg_n] = rx_data;
      lg_s[lg_n] = rx_sof_n;
      lg_e[lg_n] = rx_eof_n;
      lg_n++;
    end
    if (usr_rdy_n) begin
      if (!rx_vld_n) streak++;
      if (streak > max_streak) max_streak = streak;
    end else streak = 0;
    if (lnk_sync_req)    sync_cnt++;
    if (!rx_src_abort_n) abrt_cnt++;
  end

  int tests = 0, fails = 0;

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ent(string req, int idx, logic [31:0] d, logic s, logic e);
    chk(req, {lg_s[idx], lg_e[idx], lg_d[idx]}, {s, e, d});
  endtask

  task automatic push(logic [31:0] d, logic last, logic [1:0] e);
    mem[wp[5:0]] = {e, last, d};
    wp++;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; usr_rdy_n = 1'b1; usr_abort_n = 1'b1;
    lnk_sync_rcvd = 1'b0; tx_done = 1'b0; tx_err = 2'b00;
    cyc(4);
    chk("R1 reset", {30'd0, rx_vld_n, rx_sof_n, rx_eof_n, rx_src_abort_n},
        {30'd0, 4'b1111});
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", {29'd0, rx_vld_n, rx_sof_n, rx_eof_n, rx_src_abort_n, lnk_sync_req},
        {29'd0, 5'b11110});
    chk("R1 no pop", {33'd0, fifo_pop}, 34'd0);
  endtask

  // R2 R4: three-word packet, then a one-word packet
  task automatic t_basic;
    int b;
    usr_rdy_n = 1'b0;
    cyc(2);
    b = lg_n;
    push(32'hA000_0001, 1'b0, 2'b00);
    push(32'hA000_0002, 1'b0, 2'b00);
    push(32'hA000_0003, 1'b1, 2'b00);
    cyc(12);
    chk("R2 R4 count", 34'(lg_n - b), 34'd4);
    chk_ent("R2 first", b,     32'hA000_0001, 1'b0, 1'b1);
    chk_ent("R2 middle", b+1,  32'hA000_0002, 1'b1, 1'b1);
    chk_ent("R2 last", b+2,    32'hA000_0003, 1'b1, 1'b0);
    chk_ent("R3 R4 rx status ok", b+3, 32'h0400_00EF, 1'b0, 1'b0);
    b = lg_n;
    push(32'hB000_0001, 1'b1, 2'b01);
    cyc(10);
    chk("R2 single count", 34'(lg_n - b), 34'd2);
    chk_ent("R2 single word", b, 32'hB000_0001, 1'b0, 1'b0);
    chk_ent("R3 R4 rx status bad", b+1, 32'h0500_00EF, 1'b0, 1'b0);
  endtask

  // R5 R6: stop latency and order across stalls
  task automatic t_stop;
    int b;
    usr_rdy_n = 1'b1;
    cyc(6);
    b = lg_n;
    for (int i = 0; i < 20; i++) push(32'hC000_0000 + i, (i == 19), 2'b10);
    cyc(6);
    chk("R5 nothing while not ready", 34'(lg_n - b), 34'd0);
    usr_rdy_n = 1'b0;
    while (lg_n - b < 6) @(negedge clk);
    usr_rdy_n = 1'b1;
    max_streak = 0;
    cyc(10);
    chk("R5 overrun words", 34'(max_streak), 34'd4);
    usr_rdy_n = 1'b0;
    cyc(30);
    chk("R6 count", 34'(lg_n - b), 34'd21);
    for (int i = 0; i < 20; i++)
      chk_ent("R6 order", b+i, 32'hC000_0000 + i, (i != 0), (i != 19));
    chk_ent("R4 crc status", b+20, 32'h0600_00EF, 1'b0, 1'b0);
  endtask

  // R7: transmit status, idle and held behind an open packet
  task automatic t_tx;
    int b;
    b = lg_n;
    tx_done = 1'b1; tx_err = 2'b10;
    @(negedge clk);
    tx_done = 1'b0;
    cyc(8);
    chk("R7 idle count", 34'(lg_n - b), 34'd1);
    chk_ent("R7 R3 tx status", b, 32'h0200_00EF, 1'b0, 1'b0);
    b = lg_n;
    push(32'hD000_0001, 1'b0, 2'b00);
    push(32'hD000_0002, 1'b0, 2'b00);
    cyc(8);
    tx_done = 1'b1; tx_err = 2'b00;
    @(negedge clk);
    tx_done = 1'b0;
    cyc(6);
    chk("R7 held while open", 34'(lg_n - b), 34'd2);
    push(32'hD000_0003, 1'b1, 2'b10);
    cyc(10);
    chk("R7 total", 34'(lg_n - b), 34'd5);
    chk_ent("R7 end word", b+2, 32'hD000_0003, 1'b1, 1'b0);
    chk_ent("R7 rx status first", b+3, 32'h0600_00EF, 1'b0, 1'b0);
    chk_ent("R7 tx status after", b+4, 32'h0000_00EF, 1'b0, 1'b0);
  endtask

  // R8: user abort in mid-stream
  task automatic t_uabort;
    int b, n_at, s0, a0;
    logic any_eof;
    b = lg_n; s0 = sync_cnt; a0 = abrt_cnt;
    for (int i = 0; i < 16; i++) push(32'hE000_0000 + i, (i == 15), 2'b00);
    while (lg_n - b < 3) @(negedge clk);
    usr_abort_n = 1'b0;
    @(negedge clk);
    usr_abort_n = 1'b1;
    n_at = lg_n;
    cyc(12);
    chk("R8 no word after abort", 34'(lg_n), 34'(n_at));
    chk("R8 sync pulse", 34'(sync_cnt - s0), 34'd1);
    chk("R8 no src abort", 34'(abrt_cnt - a0), 34'd0);
    chk("R8 fifo flushed", 34'(wp - rp), 34'd0);
    any_eof = 1'b0;
    for (int i = b; i < lg_n; i++) if (!lg_e[i]) any_eof = 1'b1;
    chk("R8 no end or status", {33'd0, any_eof}, 34'd0);
    b = lg_n;
    push(32'hE100_0001, 1'b0, 2'b00);
    push(32'hE100_0002, 1'b1, 2'b00);
    cyc(10);
    chk("R8 next count", 34'(lg_n - b), 34'd3);
    chk_ent("R8 next start", b, 32'hE100_0001, 1'b0, 1'b1);
  endtask

  // R9: link SYNC in mid-stream
  task automatic t_labort;
    int b, n_at, s0, a0;
    b = lg_n; s0 = sync_cnt; a0 = abrt_cnt;
    for (int i = 0; i < 16; i++) push(32'hF000_0000 + i, (i == 15), 2'b00);
    while (lg_n - b < 4) @(negedge clk);
    lnk_sync_rcvd = 1'b1;
    @(negedge clk);
    lnk_sync_rcvd = 1'b0;
    n_at = lg_n;
    cyc(12);
    chk("R9 no word after sync", 34'(lg_n), 34'(n_at));
    chk("R9 src abort pulse", 34'(abrt_cnt - a0), 34'd1);
    chk("R9 no sync request", 34'(sync_cnt - s0), 34'd0);
    chk("R9 fifo flushed", 34'(wp - rp), 34'd0);
  endtask

  // R10: aborts outside a packet
  task automatic t_ignore;
    int b, s0, a0;
    s0 = sync_cnt; a0 = abrt_cnt;
    usr_abort_n = 1'b0; lnk_sync_rcvd = 1'b1;
    @(negedge clk);
    usr_abort_n = 1'b1; lnk_sync_rcvd = 1'b0;
    cyc(4);
    chk("R10 no pulses", 34'((sync_cnt - s0) + (abrt_cnt - a0)), 34'd0);
    b = lg_n;
    push(32'h1234_0001, 1'b0, 2'b00);
    push(32'h1234_0002, 1'b1, 2'b00);
    cyc(10);
    chk("R10 packet intact", 34'(lg_n - b), 34'd3);
    chk_ent("R10 end word", b+1, 32'h1234_0002, 1'b1, 1'b0);
    chk_ent("R10 status", b+2, 32'h0400_00EF, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    t_reset;
    t_basic;
    t_stop;
    t_tx;
    t_uabort;
    t_labort;
    t_ignore;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule